// File: doc/BRIEF.md
# FIR Multiply-Accumulate Sequencer

This block computes one finite-impulse-response output per start pulse. It takes a tap count and a sample index, walks a coefficient memory upward from entry zero and a circular sample-history memory downward from the given index, multiplies each coefficient by its sample, and sums the products into a wide accumulator. When the last product has been added, the sum appears on the result port together with a one-cycle done pulse.

Both memories are synchronous-read. The sequencer primes the operand pipeline with one read cycle and then performs one multiply-accumulate per clock. A hardware down-counter tracks the remaining taps. The fetch of the next operand pair and the termination test happen in the same cycle as the current product, so no cycle is spent on loop control.

The result port is a plain registered output that is qualified by the done pulse and holds its value until the next completion. There is no back-pressure. A consumer that needs the value must take it in the done cycle or read the held value later.

Top module: `fir_mac_seq`

## Requirements
- R1: A start seen while idle is accepted. In the next cycle the block raises both read strobes with coefficient address 0 and sample address equal to the sampled index s.
- R2: On each later read, the coefficient address is one higher than the one before. The sample address is one lower, wrapping modulo 2^ADDR_W. After k reads the addresses are k and (s-k) mod 2^ADDR_W.
- R3: The result equals the sum over k from 0 to n-1 of coef[k] times sample[(s-k) mod 2^ADDR_W]. Operands are 16-bit two's complement. The sum is kept as a 40-bit two's complement value.
- R4: For a tap count n, done is high for exactly one cycle, n+1 cycles after the accepting clock edge. The result is valid in that cycle and holds its value until the next done. After reset the result is 0.
- R5: There is no per-tap overhead. The read strobes are high in exactly max(n,1) consecutive cycles, starting the cycle after acceptance, and are low whenever the block is idle.
- R6: A start that arrives while a computation is in progress is ignored. The tap count and index sampled at acceptance stay in force. The done cycle counts as idle, so a start held high begins a new computation right after done.
- R7: A tap count of 0 gives a result of 0, with done one cycle after acceptance, following the single priming read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to compute one output |
| taps | input | CNT_W (9) | Tap count n, 0 to MAX_TAPS, sampled at acceptance |
| sample_idx | input | ADDR_W (8) | Index s of the newest sample, sampled at acceptance |
| coef_rd | output | 1 | Coefficient memory read strobe |
| coef_addr | output | ADDR_W (8) | Coefficient memory address |
| coef_data | input | DATA_W (16) | Coefficient read data, one cycle after the strobe |
| smp_rd | output | 1 | Sample memory read strobe |
| smp_addr | output | ADDR_W (8) | Sample memory address |
| smp_data | input | DATA_W (16) | Sample read data, one cycle after the strobe |
| result | output | ACC_W (40) | Accumulated output, valid with done |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions rely on three conditions. Reset releases synchronously to the clock. The tap count never exceeds MAX_TAPS, so the 40-bit sum cannot overflow for 16-bit operands. The memories return data exactly one cycle after a strobe. The stimulus keeps n between 0 and 256 and changes memory contents only while the block is idle. It also includes extreme operand values at the full tap count, which stay within the accumulator range. Out-of-contract starts are issued only while busy, as an explicit probe of the ignore rule.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRIME = 2'd1,
    ST_RUN   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/mac_loop_ctrl.sv
module mac_loop_ctrl
  import fir_mac_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] taps,
  output logic             load,
  output logic             fetch,
  output logic             mac_en,
  output logic             finish,
  output logic             busy
);
  seq_state_t       state;
  logic [CNT_W-1:0] remain;

  // Loop test runs alongside the MAC: finish and fetch decode the counter directly.
  assign load   = start && (state == ST_IDLE);
  assign mac_en = (state == ST_RUN);
  assign busy   = (state != ST_IDLE);
  assign finish = ((state == ST_PRIME) && (remain == '0)) ||
                  ((state == ST_RUN) && (remain == CNT_W'(1)));
  assign fetch  = (state == ST_PRIME) ||
                  ((state == ST_RUN) && (remain > CNT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      remain <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            remain <= taps;
            state  <= ST_PRIME;
          end
        end
        ST_PRIME: begin
          state <= (remain == '0) ? ST_IDLE : ST_RUN;
        end
        ST_RUN: begin
          remain <= remain - CNT_W'(1);
          if (remain == CNT_W'(1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: a start while busy never restarts the priming step
  assert_busy_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (state != ST_PRIME));

  // R5: every run cycle consumes exactly one tap
  assert_one_tap_per_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && remain > CNT_W'(1)) |=>
      (state == ST_RUN && remain == $past(remain) - CNT_W'(1)));

  // R7: zero taps leave straight after priming
  assert_zero_taps_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PRIME && remain == '0) |=> (state == ST_IDLE));
endmodule

// File: rtl/mac_addr_gen.sv
module mac_addr_gen #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic [ADDR_W-1:0] base_idx,
  output logic [ADDR_W-1:0] coef_ptr,
  output logic [ADDR_W-1:0] smp_ptr
);
  logic [ADDR_W-1:0] ptr_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_ptr <= '0;
      smp_ptr  <= '0;
    end else if (load) begin
      coef_ptr <= '0;
      smp_ptr  <= base_idx;
    end else if (advance) begin
      coef_ptr <= coef_ptr + ADDR_W'(1);
      smp_ptr  <= smp_ptr - ADDR_W'(1);
    end
  end

  assign ptr_sum = coef_ptr + smp_ptr;

  // R1: loading points at coefficient 0 and the newest sample
  assert_load_base_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (coef_ptr == '0 && smp_ptr == $past(base_idx)));

  // R2: pointers move in opposite directions, so their modular sum is constant
  assert_ptr_sum_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> (ptr_sum == $past(ptr_sum)));
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     mac_en,
  input  logic                     finish,
  input  logic signed [DATA_W-1:0] coef_in,
  input  logic signed [DATA_W-1:0] smp_in,
  output logic signed [ACC_W-1:0]  result,
  output logic                     done
);
  localparam int PROD_W  = 2 * DATA_W;
  localparam int GUARD_W = ACC_W - PROD_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  acc_next;

  assign prod     = coef_in * smp_in;
  assign prod_ext = {{GUARD_W{prod[PROD_W-1]}}, prod};
  assign acc_next = mac_en ? (acc + prod_ext) : acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      if (clear)       acc <= '0;
      else if (mac_en) acc <= acc_next;
      done <= finish;
      if (finish) result <= acc_next;
    end
  end

  // R4: done is a single-cycle pulse
  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: result holds between completions
  assert_result_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> $stable(result));

  // R7: finishing without any product yields zero
  assert_zero_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !mac_en) |=> (result == '0));
endmodule

// File: rtl/fir_mac_seq.sv
module fir_mac_seq #(
  parameter int DATA_W   = 16,
  parameter int ACC_W    = 40,
  parameter int ADDR_W   = 8,
  parameter int MAX_TAPS = 256,
  localparam int CNT_W   = $clog2(MAX_TAPS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [CNT_W-1:0]         taps,
  input  logic [ADDR_W-1:0]        sample_idx,
  output logic                     coef_rd,
  output logic [ADDR_W-1:0]        coef_addr,
  input  logic signed [DATA_W-1:0] coef_data,
  output logic                     smp_rd,
  output logic [ADDR_W-1:0]        smp_addr,
  input  logic signed [DATA_W-1:0] smp_data,
  output logic signed [ACC_W-1:0]  result,
  output logic                     done
);
  logic load, fetch, mac_en, finish, busy;

  mac_loop_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .taps   (taps),
    .load   (load),
    .fetch  (fetch),
    .mac_en (mac_en),
    .finish (finish),
    .busy   (busy)
  );

  mac_addr_gen #(.ADDR_W(ADDR_W)) agen_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .advance  (fetch),
    .base_idx (sample_idx),
    .coef_ptr (coef_addr),
    .smp_ptr  (smp_addr)
  );

  mac_datapath #(.DATA_W(DATA_W), .ACC_W(ACC_W)) dp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (load),
    .mac_en  (mac_en),
    .finish  (finish),
    .coef_in (coef_data),
    .smp_in  (smp_data),
    .result  (result),
    .done    (done)
  );

  assign coef_rd = fetch;
  assign smp_rd  = fetch;

  // R5: no memory traffic while idle
  assert_no_fetch_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !coef_rd);

  // R4: completion always ends the busy period
  assert_done_ends_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy || done);
endmodule

// File: tb/fir_mac_seq_tb_top.sv
module fir_mac_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [8:0] taps = '0;
  logic [7:0] sample_idx = '0;
  logic coef_rd, smp_rd, done;
  logic [7:0] coef_addr, smp_addr;
  logic signed [15:0] coef_q, smp_q;
  logic signed [39:0] result;

  logic signed [15:0] cmem [256];
  logic signed [15:0] smem [256];

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fir_mac_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .taps(taps), .sample_idx(sample_idx),
    .coef_rd(coef_rd), .coef_addr(coef_addr), .coef_data(coef_q),
    .smp_rd(smp_rd), .smp_addr(smp_addr), .smp_data(smp_q),
    .result(result), .done(done)
  );

  always @(posedge clk) begin
    if (coef_rd) coef_q <= cmem[coef_addr];
    if (smp_rd)  smp_q  <= smem[smp_addr];
  end

  // Behavioural reference model
  int cyc = 0;
  bit active = 0;
  int act_a = 0;
  int act_n = 0;
  int act_s = 0;
  logic [39:0] exp_sum = '0;
  logic [39:0] last_res = '0;

  function automatic logic [39:0] fir_ref(int n, int s);
    longint sum = 0;
    for (int k = 0; k < n; k++)
      sum += longint'(cmem[k]) * longint'(smem[(s - k) & 255]);
    return sum[39:0];
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      if (start && (!active || (cyc - act_a >= act_n + 1))) begin
        active  <= 1;
        act_a   <= cyc + 1;
        act_n   <= int'(taps);
        act_s   <= int'(sample_idx);
        exp_sum <= fir_ref(int'(taps), int'(sample_idx));
      end
      cyc <= cyc + 1;
    end
  end

  always @(negedge clk) begin
    int off;
    int nrd;
    bit exp_rd;
    bit exp_done;
    if (rst_n && !finished) begin
      off = cyc - act_a;
      nrd = (act_n > 0) ? act_n : 1;
      exp_rd = active && off >= 0 && off < nrd;
      exp_done = active && off == act_n + 1;
      chk(coef_rd == exp_rd, "R5", "coef_rd", coef_rd, exp_rd);
      chk(smp_rd == exp_rd, "R5", "smp_rd", smp_rd, exp_rd);
      if (exp_rd) begin
        if (off == 0) begin
          chk(coef_addr == 8'(off), "R1", "coef_addr", coef_addr, off & 255);
          chk(smp_addr == 8'(act_s), "R1", "smp_addr", smp_addr, act_s);
        end else begin
          chk(coef_addr == 8'(off), "R2", "coef_addr", coef_addr, off & 255);
          chk(smp_addr == 8'(act_s - off), "R2", "smp_addr", smp_addr, (act_s - off) & 255);
        end
      end
      chk(done == exp_done, (act_n == 0) ? "R7" : "R4", "done", done, exp_done);
      if (exp_done) begin
        chk(result == exp_sum, (act_n == 0) ? "R7" : "R3", "result", result, $signed(exp_sum));
        last_res = exp_sum;
      end else begin
        chk(result == last_res, "R4", "held result", result, $signed(last_res));
      end
    end
  end

  task automatic run_job(int n, int s);
    @(negedge clk);
    taps = 9'(n); sample_idx = 8'(s); start = 1;
    @(negedge clk);
    start = 0;
    repeat (n + 3) @(negedge clk);
  endtask

  task automatic finish_up();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      cmem[i] = 16'($urandom);
      smem[i] = 16'($urandom);
    end
    repeat (3) @(negedge clk);
    // R4: reset state
    chk(done == 0, "R4", "reset done", done, 0);
    chk(result == 0, "R4", "reset result", result, 0);
    chk(coef_rd == 0, "R5", "reset coef_rd", coef_rd, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    run_job(1, 5);      // R3 single tap
    run_job(4, 10);     // R1 R2 R3
    run_job(3, 1);      // R2 sample wrap
    run_job(0, 7);      // R7
    run_job(17, 200);   // R3 R5

    // R3: extreme operands over the full tap count
    for (int i = 0; i < 256; i++) begin cmem[i] = -16'sd32768; smem[i] = -16'sd32768; end
    run_job(256, 255);
    for (int i = 0; i < 256; i++) begin cmem[i] = 16'sd32767; smem[i] = -16'sd32768; end
    run_job(256, 0);
    for (int i = 0; i < 256; i++) begin
      cmem[i] = 16'($urandom);
      smem[i] = 16'($urandom);
    end

    // R6: start pulses and altered inputs while busy
    @(negedge clk);
    taps = 9'd8; sample_idx = 8'd40; start = 1;
    @(negedge clk); start = 0;
    @(negedge clk); taps = 9'd2; sample_idx = 8'd99; start = 1;
    @(negedge clk); start = 0;
    repeat (2) @(negedge clk); start = 1;
    @(negedge clk); start = 0; taps = 9'd0;
    repeat (8) @(negedge clk);

    // R6: start held high restarts in each done cycle
    taps = 9'd2; sample_idx = 8'd3; start = 1;
    repeat (12) @(negedge clk);
    start = 0;
    repeat (6) @(negedge clk);

    for (int j = 0; j < 6; j++) run_job(int'($urandom_range(0, 40)), int'($urandom_range(0, 255)));

    finish_up();
  end
endmodule